// File: doc/BRIEF.md
# Cross-PC Page-Local Address Prefetcher

This block watches the stream of issued loads. Each load carries its program counter, its address and a flag that marks it as critical. For a critical load, the target, the block looks for a different load that touched the same 4 KB page just before it. Such a load often shares a base register with the target and differs from it only by an offset. If that other load, the trigger, keeps appearing with the same offset difference, the block learns the pair. After that, every issue of the trigger PC sends a line-aligned prefetch toward the L1: the trigger's address shifted by the learned difference. The prefetch leaves early enough that the data arrives before the target asks for it.

The block does not decide which loads are critical, and it holds no cache storage. It keeps three parameterised tables. The page history records, for each recently touched page, the last PC and offset that touched it. The association table holds one entry per target, with its candidate trigger, the signed difference and a confidence count. A small filter remembers the lines issued most recently. Requests leave through a one-deep valid/ready output register.

Top module: `xpage_prefetch`

## Requirements
- R1: After reset the prefetch output is idle (`pfValid` = 0) and all tables are empty, so no load produces a request until an association has been trained again.
- R2: A critical load of PC T in a page whose history entry was last written by a different PC C makes C the candidate trigger for T. The difference is T's page offset minus C's page offset (bits 11:0), kept as a signed 13-bit value, so negative differences are supported.
- R3: An association becomes trained on the CONF_THRESH-th consecutive observation of the same trigger and difference (default 3). Until then, loads of the candidate trigger produce no request.
- R4: An observation with a different trigger PC or a different difference, before training, replaces the candidate and restarts the count at one.
- R5: A trained association stays fixed. Later observations for that target do not change its trigger or its difference.
- R6: Every load of a trained trigger PC, critical or not, produces a request one clock after the load. The request address is the trigger load's page number with the offset (trigger offset + difference), and its low LINE_BITS bits (default 6) are cleared.
- R7: If the trigger offset plus the difference falls outside 0..4095, no request is produced.
- R8: A request whose line equals one of the last FILT_DEPTH issued lines (default 4) is dropped. Once that many later lines have been issued, the same line is issued again.
- R9: While `pfValid` = 1 and `pfReady` = 0, the request and its address stay unchanged. A new request that arises during that time is dropped, not queued, and it does not enter the filter.
- R10: The page history holds HIST_DEPTH distinct pages (default 64) and replaces the oldest inserted page. A page that has been pushed out gives no candidate.
- R11: Loads of a target PC that are not flagged critical do not train it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ldValid | input | 1 | A load issues this cycle |
| ldPc | input | PC_W | Program counter of the load |
| ldAddr | input | ADDR_W | Address of the load |
| ldCritical | input | 1 | Load is on the critical path |
| pfValid | output | 1 | Prefetch request present |
| pfAddr | output | ADDR_W | Line-aligned prefetch address |
| pfReady | input | 1 | Consumer accepts the request |

## Verification
The internal state of this block becomes visible only when a trigger fires. A wrong confidence count or a lost reset of that count shows up as a request that comes one observation early or one observation late. A wrong page-history entry, or an eviction that comes too early or too late, changes whether a target trains at all. Both faults are seen on `pfValid` in the cycle after the next trigger load. A wrong difference or a wrong page check shows up in `pfAddr` in that same cycle. Filter and handshake faults show up as a repeated or missing line within a few issues.

// File: rtl/xpage_prefetch_pkg.sv
package xpage_prefetch_pkg;

  typedef struct packed {
    logic histHit;
    logic candValid;
    logic candMatch;
    logic tgtHit;
    logic tgtTrained;
    logic confAtLast;
    logic trigHit;
    logic inPage;
    logic filtHit;
    logic outBusy;
  } xpfStatus_t;

  typedef struct packed {
    logic histWrite;
    logic tgtAlloc;
    logic tgtBump;
    logic tgtTrain;
    logic tgtRestart;
    logic pfFire;
  } xpfStrobe_t;

endpackage

// File: rtl/xpage_prefetch_ctrl.sv
module xpage_prefetch_ctrl
  import xpage_prefetch_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       ldValid,
  input  logic       ldCritical,
  input  xpfStatus_t status,
  output xpfStrobe_t strobe
);

  logic observe;
  logic learning;

  assign observe  = ldValid && ldCritical && status.candValid;
  assign learning = observe && status.tgtHit && !status.tgtTrained;

  always_comb begin
    strobe            = '0;
    strobe.histWrite  = ldValid;
    strobe.tgtAlloc   = observe && !status.tgtHit;
    strobe.tgtBump    = learning && status.candMatch && !status.confAtLast;
    strobe.tgtTrain   = learning && status.candMatch && status.confAtLast;
    strobe.tgtRestart = learning && !status.candMatch;
    strobe.pfFire     = ldValid && status.trigHit && status.inPage &&
                        !status.filtHit && !status.outBusy;
  end

  // R4, R5: at most one action on the association table per load
  assert_one_train_action_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.tgtAlloc, strobe.tgtBump, strobe.tgtTrain, strobe.tgtRestart}));

endmodule

// File: rtl/xpage_prefetch_dp.sv
module xpage_prefetch_dp
  import xpage_prefetch_pkg::*;
#(
  parameter int PC_W        = 32,
  parameter int ADDR_W      = 32,
  parameter int PAGE_BITS   = 12,
  parameter int LINE_BITS   = 6,
  parameter int HIST_DEPTH  = 64,
  parameter int TGT_DEPTH   = 4,
  parameter int FILT_DEPTH  = 4,
  parameter int CONF_THRESH = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PC_W-1:0]   ldPc,
  input  logic [ADDR_W-1:0] ldAddr,
  input  logic              pfReady,
  input  xpfStrobe_t        strobe,
  output xpfStatus_t        status,
  output logic              pfValid,
  output logic [ADDR_W-1:0] pfAddr
);

  localparam int PAGE_W  = ADDR_W - PAGE_BITS;
  localparam int DELTA_W = PAGE_BITS + 1;
  localparam int SUM_W   = PAGE_BITS + 2;
  localparam int LINE_W  = ADDR_W - LINE_BITS;
  localparam int HIST_IW = $clog2(HIST_DEPTH > 1 ? HIST_DEPTH : 2);
  localparam int TGT_IW  = $clog2(TGT_DEPTH > 1 ? TGT_DEPTH : 2);
  localparam int FILT_IW = $clog2(FILT_DEPTH > 1 ? FILT_DEPTH : 2);
  localparam int CONF_W  = $clog2(CONF_THRESH + 1);

  // page history
  logic                 histVld  [HIST_DEPTH];
  logic [PAGE_W-1:0]    histPage [HIST_DEPTH];
  logic [PC_W-1:0]      histPc   [HIST_DEPTH];
  logic [PAGE_BITS-1:0] histOff  [HIST_DEPTH];
  logic [HIST_IW-1:0]   histPtr;

  // association table
  logic                 tVld     [TGT_DEPTH];
  logic [PC_W-1:0]      tPc      [TGT_DEPTH];
  logic [PC_W-1:0]      tTrig    [TGT_DEPTH];
  logic [DELTA_W-1:0]   tDelta   [TGT_DEPTH];
  logic [CONF_W-1:0]    tConf    [TGT_DEPTH];
  logic                 tTrained [TGT_DEPTH];
  logic [TGT_IW-1:0]    tPtr;

  // recent line filter
  logic                 fVld  [FILT_DEPTH];
  logic [LINE_W-1:0]    fLine [FILT_DEPTH];
  logic [FILT_IW-1:0]   fPtr;

  logic [PAGE_W-1:0]    ldPage;
  logic [PAGE_BITS-1:0] ldOff;
  logic                 histHit;
  logic [HIST_IW-1:0]   histIdx;
  logic [PC_W-1:0]      candPc;
  logic [DELTA_W-1:0]   candDelta;
  logic                 tgtHit;
  logic [TGT_IW-1:0]    tgtIdx;
  logic                 trigHit;
  logic [TGT_IW-1:0]    trigIdx;
  logic [SUM_W-1:0]     offSum;
  logic [LINE_W-1:0]    nextLine;
  logic                 filtHit;

  assign ldPage = ldAddr[ADDR_W-1:PAGE_BITS];
  assign ldOff  = ldAddr[PAGE_BITS-1:0];

  always_comb begin
    histHit = 1'b0;
    histIdx = '0;
    for (int i = HIST_DEPTH - 1; i >= 0; i--) begin
      if (histVld[i] && histPage[i] == ldPage) begin
        histHit = 1'b1;
        histIdx = HIST_IW'(i);
      end
    end
  end

  assign candPc    = histPc[histIdx];
  assign candDelta = {1'b0, ldOff} - {1'b0, histOff[histIdx]};

  always_comb begin
    tgtHit  = 1'b0;
    tgtIdx  = '0;
    trigHit = 1'b0;
    trigIdx = '0;
    for (int i = TGT_DEPTH - 1; i >= 0; i--) begin
      if (tVld[i] && tPc[i] == ldPc) begin
        tgtHit = 1'b1;
        tgtIdx = TGT_IW'(i);
      end
      if (tVld[i] && tTrained[i] && tTrig[i] == ldPc) begin
        trigHit = 1'b1;
        trigIdx = TGT_IW'(i);
      end
    end
  end

  assign offSum   = {2'b00, ldOff} + {tDelta[trigIdx][DELTA_W-1], tDelta[trigIdx]};
  assign nextLine = {ldPage, offSum[PAGE_BITS-1:0]} >> LINE_BITS;

  always_comb begin
    filtHit = 1'b0;
    for (int i = 0; i < FILT_DEPTH; i++) begin
      if (fVld[i] && fLine[i] == nextLine) filtHit = 1'b1;
    end
  end

  always_comb begin
    status            = '0;
    status.histHit    = histHit;
    status.candValid  = histHit && (candPc != ldPc);
    status.tgtHit     = tgtHit;
    status.tgtTrained = tTrained[tgtIdx];
    status.candMatch  = (tTrig[tgtIdx] == candPc) && (tDelta[tgtIdx] == candDelta);
    status.confAtLast = (tConf[tgtIdx] == CONF_W'(CONF_THRESH - 1));
    status.trigHit    = trigHit;
    status.inPage     = (offSum[SUM_W-1:PAGE_BITS] == 2'b00);
    status.filtHit    = filtHit;
    status.outBusy    = pfValid && !pfReady;
  end

  // page history update, oldest inserted page replaced
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      histPtr <= '0;
      for (int i = 0; i < HIST_DEPTH; i++) begin
        histVld[i]  <= 1'b0;
        histPage[i] <= '0;
        histPc[i]   <= '0;
        histOff[i]  <= '0;
      end
    end else if (strobe.histWrite) begin
      if (histHit) begin
        histPc[histIdx]  <= ldPc;
        histOff[histIdx] <= ldOff;
      end else begin
        histVld[histPtr]  <= 1'b1;
        histPage[histPtr] <= ldPage;
        histPc[histPtr]   <= ldPc;
        histOff[histPtr]  <= ldOff;
        histPtr <= (histPtr == HIST_IW'(HIST_DEPTH - 1)) ? '0 : histPtr + 1'b1;
      end
    end
  end

  // association table update
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tPtr <= '0;
      for (int i = 0; i < TGT_DEPTH; i++) begin
        tVld[i]     <= 1'b0;
        tPc[i]      <= '0;
        tTrig[i]    <= '0;
        tDelta[i]   <= '0;
        tConf[i]    <= '0;
        tTrained[i] <= 1'b0;
      end
    end else begin
      if (strobe.tgtAlloc) begin
        tVld[tPtr]     <= 1'b1;
        tPc[tPtr]      <= ldPc;
        tTrig[tPtr]    <= candPc;
        tDelta[tPtr]   <= candDelta;
        tConf[tPtr]    <= CONF_W'(1);
        tTrained[tPtr] <= (CONF_THRESH <= 1);
        tPtr <= (tPtr == TGT_IW'(TGT_DEPTH - 1)) ? '0 : tPtr + 1'b1;
      end
      if (strobe.tgtBump) begin
        tConf[tgtIdx] <= tConf[tgtIdx] + 1'b1;
      end
      if (strobe.tgtTrain) begin
        tConf[tgtIdx]    <= tConf[tgtIdx] + 1'b1;
        tTrained[tgtIdx] <= 1'b1;
      end
      if (strobe.tgtRestart) begin
        tTrig[tgtIdx]  <= candPc;
        tDelta[tgtIdx] <= candDelta;
        tConf[tgtIdx]  <= CONF_W'(1);
      end
    end
  end

  // filter and output register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fPtr    <= '0;
      pfValid <= 1'b0;
      pfAddr  <= '0;
      for (int i = 0; i < FILT_DEPTH; i++) begin
        fVld[i]  <= 1'b0;
        fLine[i] <= '0;
      end
    end else begin
      if (strobe.pfFire) begin
        fVld[fPtr]  <= 1'b1;
        fLine[fPtr] <= nextLine;
        fPtr        <= (fPtr == FILT_IW'(FILT_DEPTH - 1)) ? '0 : fPtr + 1'b1;
        pfValid     <= 1'b1;
        pfAddr      <= {nextLine, {LINE_BITS{1'b0}}};
      end else if (pfReady) begin
        pfValid <= 1'b0;
      end
    end
  end

  // R9: a stalled request holds its address
  assert_hold_stalled_R9: assert property (@(posedge clk) disable iff (!rstN)
    (pfValid && !pfReady) |=> (pfValid && $stable(pfAddr)));

  // R6: an issued request stays in the trigger load's page
  assert_same_page_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pfFire |=> (pfAddr[ADDR_W-1:PAGE_BITS] == $past(ldAddr[ADDR_W-1:PAGE_BITS])));

  // R3: a trained entry has seen exactly the threshold count
  for (genvar g = 0; g < TGT_DEPTH; g++) begin : gConfChk
    assert_trained_conf_R3: assert property (@(posedge clk) disable iff (!rstN)
      tTrained[g] |-> (tConf[g] == CONF_W'(CONF_THRESH)));
  end

endmodule

// File: rtl/xpage_prefetch.sv
module xpage_prefetch
  import xpage_prefetch_pkg::*;
#(
  parameter int PC_W        = 32,
  parameter int ADDR_W      = 32,
  parameter int PAGE_BITS   = 12,
  parameter int LINE_BITS   = 6,
  parameter int HIST_DEPTH  = 64,
  parameter int TGT_DEPTH   = 4,
  parameter int FILT_DEPTH  = 4,
  parameter int CONF_THRESH = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ldValid,
  input  logic [PC_W-1:0]   ldPc,
  input  logic [ADDR_W-1:0] ldAddr,
  input  logic              ldCritical,
  output logic              pfValid,
  output logic [ADDR_W-1:0] pfAddr,
  input  logic              pfReady
);

  xpfStatus_t status;
  xpfStrobe_t strobe;

  xpage_prefetch_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .ldValid    (ldValid),
    .ldCritical (ldCritical),
    .status     (status),
    .strobe     (strobe)
  );

  xpage_prefetch_dp #(
    .PC_W        (PC_W),
    .ADDR_W      (ADDR_W),
    .PAGE_BITS   (PAGE_BITS),
    .LINE_BITS   (LINE_BITS),
    .HIST_DEPTH  (HIST_DEPTH),
    .TGT_DEPTH   (TGT_DEPTH),
    .FILT_DEPTH  (FILT_DEPTH),
    .CONF_THRESH (CONF_THRESH)
  ) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ldPc    (ldPc),
    .ldAddr  (ldAddr),
    .pfReady (pfReady),
    .strobe  (strobe),
    .status  (status),
    .pfValid (pfValid),
    .pfAddr  (pfAddr)
  );

endmodule

// File: tb/test_xpage_prefetch.sv
module test_xpage_prefetch;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ldValid = 1'b0;
  logic [31:0] ldPc = '0;
  logic [31:0] ldAddr = '0;
  logic        ldCritical = 1'b0;
  logic        pfValid;
  logic [31:0] pfAddr;
  logic        pfReady = 1'b1;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  xpage_prefetch i_xpage_prefetch (
    .clk        (clk),
    .rstN       (rstN),
    .ldValid    (ldValid),
    .ldPc       (ldPc),
    .ldAddr     (ldAddr),
    .ldCritical (ldCritical),
    .pfValid    (pfValid),
    .pfAddr     (pfAddr),
    .pfReady    (pfReady)
  );

  typedef struct packed {
    logic [31:0] pc;
    logic [31:0] addr;
    logic        crit;
    logic        expV;
    logic [31:0] expA;
    logic [7:0]  req;
  } vec_t;

  // trigger PC 0x100, target PC 0x200, learned difference +0x80
  localparam vec_t VEC [16] = '{
    '{32'h100, 32'h12345100, 1'b0, 1'b0, 32'h0,        8'd1},  // R1 untrained
    '{32'h200, 32'h12345180, 1'b1, 1'b0, 32'h0,        8'd2},  // R2 first obs
    '{32'h100, 32'h12345100, 1'b0, 1'b0, 32'h0,        8'd3},  // R3 not yet
    '{32'h200, 32'h12345180, 1'b1, 1'b0, 32'h0,        8'd3},  // second obs
    '{32'h100, 32'h12345100, 1'b0, 1'b0, 32'h0,        8'd3},  // R3 not yet
    '{32'h200, 32'h12345180, 1'b1, 1'b0, 32'h0,        8'd3},  // trained
    '{32'h100, 32'h12345200, 1'b0, 1'b1, 32'h12345280, 8'd6},  // R6 fire
    '{32'h100, 32'h12345200, 1'b0, 1'b0, 32'h0,        8'd8},  // R8 repeat
    '{32'h100, 32'h00777F90, 1'b0, 1'b0, 32'h0,        8'd7},  // R7 off page
    '{32'h100, 32'h00777010, 1'b0, 1'b1, 32'h00777080, 8'd6},  // R6 aligned
    '{32'h200, 32'h00777500, 1'b1, 1'b0, 32'h0,        8'd5},  // R5 other obs
    '{32'h100, 32'h00888000, 1'b1, 1'b1, 32'h00888080, 8'd5},  // R5 kept
    '{32'h100, 32'h12345200, 1'b0, 1'b0, 32'h0,        8'd8},  // R8 in window
    '{32'h100, 32'h00999000, 1'b0, 1'b1, 32'h00999080, 8'd8},
    '{32'h100, 32'h00AAA000, 1'b0, 1'b1, 32'h00AAA080, 8'd8},
    '{32'h100, 32'h12345200, 1'b0, 1'b1, 32'h12345280, 8'd8}   // R8 aged out
  };

  task automatic chk(input string req, input logic expV, input logic [31:0] expA);
    logic [32:0] got;
    logic [32:0] exp;
    got = {pfValid, pfValid ? pfAddr : 32'h0};
    exp = {expV, expV ? expA : 32'h0};
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got valid=%0b addr=%h, expected valid=%0b addr=%h",
               req, got[32], got[31:0], exp[32], exp[31:0]);
    end
  endtask

  // one load per cycle; the result is visible just after the capturing edge
  task automatic doLoad(input logic [31:0] pc, input logic [31:0] addr, input logic crit);
    @(negedge clk);
    ldValid    = 1'b1;
    ldPc       = pc;
    ldAddr     = addr;
    ldCritical = crit;
    @(posedge clk);
    #2;
    ldValid    = 1'b0;
    ldCritical = 1'b0;
  endtask

  task automatic idle();
    @(posedge clk);
    #2;
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog: got running, expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    idle();
    chk("R1 reset idle", 1'b0, 32'h0);

    for (int i = 0; i < 16; i++) begin
      doLoad(VEC[i].pc, VEC[i].addr, VEC[i].crit);
      chk($sformatf("R%0d vector %0d", VEC[i].req, i), VEC[i].expV, VEC[i].expA);
    end

    // R4 restart on a changed candidate, R2 negative difference
    doLoad(32'h400, 32'h0BBB0800, 1'b0);
    doLoad(32'h300, 32'h0BBB0700, 1'b1);
    doLoad(32'h400, 32'h0BBB0800, 1'b0);
    doLoad(32'h300, 32'h0BBB0700, 1'b1);
    doLoad(32'h500, 32'h0BBB0900, 1'b0);
    doLoad(32'h300, 32'h0BBB0700, 1'b1);
    doLoad(32'h500, 32'h0BBB0900, 1'b0);
    doLoad(32'h300, 32'h0BBB0700, 1'b1);
    doLoad(32'h500, 32'h0CCC0900, 1'b0);
    chk("R4 count restarted", 1'b0, 32'h0);
    doLoad(32'h500, 32'h0BBB0900, 1'b0);
    doLoad(32'h300, 32'h0BBB0700, 1'b1);
    doLoad(32'h500, 32'h0CCC0900, 1'b0);
    chk("R2 negative difference", 1'b1, 32'h0CCC0700);
    doLoad(32'h400, 32'h0CCC0800, 1'b0);
    chk("R4 old candidate dropped", 1'b0, 32'h0);

    // R11 non-critical target loads
    for (int i = 0; i < 3; i++) begin
      doLoad(32'h700, 32'h0DDD0000, 1'b0);
      doLoad(32'h600, 32'h0DDD0040, 1'b0);
    end
    doLoad(32'h700, 32'h0EEE0000, 1'b0);
    chk("R11 no training", 1'b0, 32'h0);

    // R10 page pushed out of the history
    doLoad(32'h800, 32'h0F000000, 1'b0);
    for (int i = 0; i < 64; i++) begin
      doLoad(32'h900, 32'h01000000 + (i << 12), 1'b0);
    end
    doLoad(32'hA00, 32'h0F000040, 1'b1);
    doLoad(32'h800, 32'h0F000000, 1'b0);
    doLoad(32'hA00, 32'h0F000040, 1'b1);
    doLoad(32'h800, 32'h0F000000, 1'b0);
    doLoad(32'hA00, 32'h0F000040, 1'b1);
    doLoad(32'h800, 32'h0F100000, 1'b0);
    chk("R10 evicted page", 1'b0, 32'h0);

    // R9 stall holds the request and drops a new one
    @(negedge clk);
    pfReady = 1'b0;
    doLoad(32'h100, 32'h02000000, 1'b0);
    chk("R9 issued", 1'b1, 32'h02000080);
    doLoad(32'h100, 32'h03000000, 1'b0);
    chk("R9 held", 1'b1, 32'h02000080);
    idle();
    chk("R9 still held", 1'b1, 32'h02000080);
    @(negedge clk);
    pfReady = 1'b1;
    idle();
    chk("R9 accepted, nothing queued", 1'b0, 32'h0);
    doLoad(32'h100, 32'h03000000, 1'b0);
    chk("R9 dropped line not filtered", 1'b1, 32'h03000080);

    // R1 reset clears trained state
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    doLoad(32'h100, 32'h04000000, 1'b0);
    chk("R1 tables cleared", 1'b0, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule